// File: doc/BRIEF.md
# Two-Stage Regulator Soft-Start Sequencer

This block brings a voltage regulator's digital reference up from zero in a fixed order. It waits until the supply power-on-reset flag and the two rail enables are all high, then counts a fixed settling delay. It then raises the DAC code one step per soft-start tick until it reaches a boot level, and parks there for a fixed hold time. After the hold it qualifies the VID input and moves the code, one step per tick, to the VID target less a configurable offset. That move can go up or down. A fixed time after the code settles, the block raises its ready output.

The DAC code is unsigned, and each step is 6.25 mV, so the 1.1 V boot level is code 176. The soft-start tick comes from a separate oscillator and sets the ramp rate. A VID flagged as the OFF code latches the block in shutdown. The block leaves that state only when one of the three enables goes low. Undervoltage and overvoltage flags pull ready low while they are present.

Top module: `vreg_softstart`

## Requirements
- R1: After a synchronous reset, dac_code is 0 and vr_ready is 0.
- R2: While any of por_ok, pwr_en or vtt_en is low, dac_code stays 0 and vr_ready stays 0.
- R3: With ss_tick held high, dac_code first changes from 0 to 1 exactly DELAY_CYC+1 rising edges after the first edge at which all three enables are seen high.
- R4: In both ramps, dac_code moves by exactly one code on each edge where ss_tick is high, and it holds on edges where ss_tick is low. With ss_tick held high, the boot code BOOT_CODE (176) is reached DELAY_CYC+176 edges after the enables are seen.
- R5: When vid_valid is held high, the first step of the second ramp comes HOLD_CYC+VID_CHK_CYC+2 edges after the edge at which dac_code reached BOOT_CODE.
- R6: After the hold, the VID is sampled only once vid_valid has been high for VID_CHK_CYC consecutive edges. A shorter pulse has no effect. The first step comes VID_CHK_CYC edges after the first edge at which vid_valid is seen high.
- R7: The second ramp ends at vid_code minus OFFSET_CODES, floored at 0. It steps up or down as needed.
- R8: vr_ready rises READY_CYC+2 edges after dac_code reaches the target. This is HOLD_CYC+VID_CHK_CYC+READY_CYC+3+|target-176| edges after boot is reached.
- R9: While vr_ready is high, either fault flag high makes vr_ready low from the next edge. When the flag clears, vr_ready returns high on the following edge.
- R10: If the code sampled after the hold has vid_valid and vid_off both high, the block shuts down: dac_code goes to 0 and vr_ready stays 0. It stays shut down, whatever the VID input does, until one enable goes low. After that it restarts with the R3 timing.
- R11: vid_valid and vid_off both high during the second ramp, the ready delay or while running force the same latched shutdown. vr_ready goes low on the next edge.
- R12: When any enable goes low, dac_code is 0 and vr_ready is 0 from the next edge. When all enables return high, the sequence restarts with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply power-on-reset good |
| pwr_en | input | 1 | Power enable |
| vtt_en | input | 1 | Termination-rail enable |
| ss_tick | input | 1 | Soft-start step tick, one step per high cycle |
| vid_code | input | CODE_W | Decoded VID target code, in 6.25 mV units |
| vid_valid | input | 1 | VID code is valid |
| vid_off | input | 1 | VID is the OFF code (used with vid_valid) |
| uv_fault | input | 1 | Undervoltage flag |
| ov_fault | input | 1 | Overvoltage flag |
| dac_code | output | CODE_W | Reference DAC code |
| vr_ready | output | 1 | Regulator ready |

## Verification
The bench builds the block with DELAY_CYC=40, HOLD_CYC=12, VID_CHK_CYC=4, READY_CYC=10 and OFFSET_CODES=2, in place of defaults sized for a 50 MHz clock. Each full start-up then takes a few hundred cycles, so exact phase lengths can be checked on about ten start-ups. These include up and down second ramps, a target floored at zero and a target equal to boot. The VID qualification window of 4 lets a 2-cycle valid pulse fall short. The offset of 2 makes the target differ from the raw VID code.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RAMP1,
    ST_HOLD,
    ST_VIDCHK,
    ST_RAMP2,
    ST_RDLY,
    ST_RUN,
    ST_OFF
  } ss_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/ss_timer.sv
module ss_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != {CNT_W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ss_stepper.sv
module ss_stepper #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] code,
  output logic              at_tgt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
    end else if (step && (code < tgt)) begin
      code <= code + 1'b1;
    end else if (step && (code > tgt)) begin
      code <= code - 1'b1;
    end
  end

  assign at_tgt = (code == tgt);

  // R4: at most one code per edge outside a clear
  a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> (code == $past(code) || code == $past(code) + 1'b1 ||
                code == $past(code) - 1'b1));

  // R4: no movement on an edge without a step request
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(code));

endmodule

// File: rtl/ss_vid_qual.sv
module ss_vid_qual #(
  parameter int CODE_W       = 8,
  parameter int CHK_CYC      = 25,
  parameter int OFFSET_CODES = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              vid_valid,
  input  logic              vid_off,
  input  logic [CODE_W-1:0] vid_code,
  output logic              fire,
  output logic              off_req,
  output logic [CODE_W-1:0] tgt
);

  localparam int QW = (CHK_CYC > 1) ? $clog2(CHK_CYC) : 1;
  localparam logic [QW-1:0] LAST = QW'(CHK_CYC - 1);
  localparam logic [CODE_W-1:0] OFS = CODE_W'(OFFSET_CODES);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !en || !vid_valid) begin
      run_q <= '0;
    end else if (run_q != LAST) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign fire    = en && vid_valid && (run_q == LAST);
  assign off_req = vid_off;
  assign tgt     = (vid_code > OFS) ? (vid_code - OFS) : '0;

  generate
    if (CHK_CYC > 1) begin : g_multi
      // R6: a sample needs valid on the previous edge too
      a_r6_valid_run: assert property (@(posedge clk) disable iff (rst)
        fire |-> ($past(vid_valid) && $past(en)));
    end
  endgenerate

endmodule

// File: rtl/vreg_softstart.sv
module vreg_softstart #(
  parameter int CODE_W       = 8,
  parameter int BOOT_CODE    = 176,
  parameter int OFFSET_CODES = 0,
  parameter int DELAY_CYC    = 68000,
  parameter int HOLD_CYC     = 4250,
  parameter int VID_CHK_CYC  = 25,
  parameter int READY_CYC    = 4250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_ok,
  input  logic              pwr_en,
  input  logic              vtt_en,
  input  logic              ss_tick,
  input  logic [CODE_W-1:0] vid_code,
  input  logic              vid_valid,
  input  logic              vid_off,
  input  logic              uv_fault,
  input  logic              ov_fault,
  output logic [CODE_W-1:0] dac_code,
  output logic              vr_ready
);
  import ss_pkg::*;

  localparam int unsigned MAXC = max3(DELAY_CYC, HOLD_CYC, READY_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_END  = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RDY_END  = CNT_W'(READY_CYC - 1);
  localparam logic [CODE_W-1:0] BOOT = CODE_W'(BOOT_CODE);

  ss_state_t         state_q, state_d;
  logic              en_ok, off_now;
  logic [CNT_W-1:0]  tmr;
  logic              tmr_clr;
  logic [CODE_W-1:0] tgt_q, step_tgt, q_tgt;
  logic              step_en, stp_clr, at_tgt;
  logic              q_fire, q_off;
  logic              ready_q;

  assign en_ok   = por_ok && pwr_en && vtt_en;
  assign off_now = vid_valid && vid_off;

  always_comb begin
    state_d = state_q;
    if (!en_ok) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_DELAY;
        ST_DELAY:  if (tmr == DLY_END) state_d = ST_RAMP1;
        ST_RAMP1:  if (at_tgt) state_d = ST_HOLD;
        ST_HOLD:   if (tmr == HOLD_END) state_d = ST_VIDCHK;
        ST_VIDCHK: if (q_fire) state_d = q_off ? ST_OFF : ST_RAMP2;
        ST_RAMP2: begin
          if (off_now)     state_d = ST_OFF;
          else if (at_tgt) state_d = ST_RDLY;
        end
        ST_RDLY: begin
          if (off_now)             state_d = ST_OFF;
          else if (tmr == RDY_END) state_d = ST_RUN;
        end
        ST_RUN:    if (off_now) state_d = ST_OFF;
        ST_OFF:    state_d = ST_OFF;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_VIDCHK && q_fire) begin
        tgt_q <= q_tgt;
      end
      ready_q <= (state_q == ST_RUN) && en_ok && !uv_fault && !ov_fault && !off_now;
    end
  end

  assign tmr_clr  = (state_d != state_q);
  assign step_tgt = (state_q == ST_RAMP2) ? tgt_q : BOOT;
  assign step_en  = ss_tick && en_ok && ((state_q == ST_RAMP1) || (state_q == ST_RAMP2));
  assign stp_clr  = !en_ok || (state_q == ST_OFF);

  ss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (tmr)
  );

  ss_stepper #(.CODE_W(CODE_W)) u_stepper (
    .clk    (clk),
    .rst    (rst),
    .clr    (stp_clr),
    .step   (step_en),
    .tgt    (step_tgt),
    .code   (dac_code),
    .at_tgt (at_tgt)
  );

  ss_vid_qual #(
    .CODE_W       (CODE_W),
    .CHK_CYC      (VID_CHK_CYC),
    .OFFSET_CODES (OFFSET_CODES)
  ) u_qual (
    .clk       (clk),
    .rst       (rst),
    .en        (state_q == ST_VIDCHK),
    .vid_valid (vid_valid),
    .vid_off   (vid_off),
    .vid_code  (vid_code),
    .fire      (q_fire),
    .off_req   (q_off),
    .tgt       (q_tgt)
  );

  assign vr_ready = ready_q;

  // R2: idle means a zero reference
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (dac_code == '0));

  // R12: enable loss clears code and ready on the next edge
  a_r12_enable_drop: assert property (@(posedge clk) disable iff (rst)
    (!en_ok) |=> (dac_code == '0 && !vr_ready));

  // R9: faults drop ready
  a_r9_fault_drop: assert property (@(posedge clk) disable iff (rst)
    (uv_fault || ov_fault) |=> !vr_ready);

  // R10: shutdown is held while the enables stay high
  a_r10_off_latched: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && en_ok) |=> (state_q == ST_OFF));

  // R10: shutdown empties the reference
  a_r10_off_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF) |=> (dac_code == '0 && !vr_ready));

  // R8: ready only with the code on its target
  a_r8_ready_on_target: assert property (@(posedge clk) disable iff (rst)
    vr_ready |-> (dac_code == tgt_q));

endmodule

// File: tb/vreg_softstart_bench.sv
`timescale 1ns/1ps
module vreg_softstart_bench;

  localparam int CW = 8;
  localparam int D  = 40;
  localparam int H  = 12;
  localparam int V  = 4;
  localparam int R  = 10;
  localparam int OF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_ok = 1'b0, pwr_en = 1'b0, vtt_en = 1'b0, ss_tick = 1'b0;
  logic [CW-1:0] vid_code = '0;
  logic vid_valid = 1'b0, vid_off = 1'b0, uv_fault = 1'b0, ov_fault = 1'b0;
  logic [CW-1:0] dac_code;
  logic vr_ready;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int exp_q[$];
  bit sb_on = 1'b0;
  int prev_dac = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vreg_softstart #(
    .CODE_W(CW), .BOOT_CODE(176), .OFFSET_CODES(OF),
    .DELAY_CYC(D), .HOLD_CYC(H), .VID_CHK_CYC(V), .READY_CYC(R)
  ) u_vreg_softstart (
    .clk(clk), .rst(rst), .por_ok(por_ok), .pwr_en(pwr_en), .vtt_en(vtt_en),
    .ss_tick(ss_tick), .vid_code(vid_code), .vid_valid(vid_valid), .vid_off(vid_off),
    .uv_fault(uv_fault), .ov_fault(ov_fault), .dac_code(dac_code), .vr_ready(vr_ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares every code change with the queue
  always @(negedge clk) begin
    if (sb_on && int'(dac_code) != prev_dac) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected code change: got %0d expected none", dac_code);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(dac_code) != e) begin
          n_fail++;
          $display("FAIL R7 ramp sequence: got %0d expected %0d", dac_code, e);
        end
      end
    end
    prev_dac = int'(dac_code);
  end

  task automatic sb_ramp(input int from, input int to);
    if (to > from) for (int v = from + 1; v <= to; v++) exp_q.push_back(v);
    else           for (int v = from - 1; v >= to; v--) exp_q.push_back(v);
  endtask

  task automatic wait_eq(input int val, output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (int'(dac_code) == val) begin t = cyc; break; end
    end
  endtask

  task automatic wait_ne(input int val, output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (int'(dac_code) != val) begin t = cyc; break; end
    end
  endtask

  task automatic wait_rdy(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (vr_ready) begin t = cyc; break; end
    end
  endtask

  // drop power-on-reset for one edge, arm the scoreboard, restart
  task automatic restart(input bit use_sb, output int c0);
    por_ok = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sb_on = use_sb;
    por_ok = 1'b1;
    c0 = cyc + 1;
  endtask

  task automatic sb_done(input string req);
    chk(req, "scoreboard items left", exp_q.size(), 0);
    sb_on = 1'b0;
    exp_q.delete();
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c0, t, tb, tf, tr, x;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1", "dac after reset", dac_code, 0);
    chk("R1", "ready after reset", vr_ready, 0);

    // R2: partial enables
    ss_tick = 1'b1;
    por_ok = 1'b1; pwr_en = 1'b1; vtt_en = 1'b0;
    repeat (100) @(negedge clk);
    chk("R2", "dac without vtt_en", dac_code, 0);
    por_ok = 1'b0; vtt_en = 1'b1;
    repeat (60) @(negedge clk);
    chk("R2", "dac without por_ok", dac_code, 0);
    chk("R2", "ready without por_ok", vr_ready, 0);

    // full start, upward second ramp to 200-2
    vid_code = 8'd200; vid_valid = 1'b1;
    sb_ramp(0, 176); sb_ramp(176, 198);
    restart(1'b1, c0);
    wait_ne(0, t);
    chk("R3", "first step latency", t - c0, D + 1);
    wait_eq(176, tb);
    chk("R4", "boot reach latency", tb - c0, D + 176);
    wait_ne(176, t);
    chk("R5", "hold to second ramp", t - tb, H + V + 2);
    wait_eq(198, tf);
    chk("R7", "second ramp end", tf - tb, H + V + 1 + 22);
    wait_rdy(tr);
    chk("R8", "ready delay", tr - tf, R + 2);
    sb_done("R7");

    // R9: faults
    @(negedge clk);
    uv_fault = 1'b1;
    @(negedge clk);
    chk("R9", "ready under uv", vr_ready, 0);
    uv_fault = 1'b0;
    @(negedge clk);
    chk("R9", "ready after uv clears", vr_ready, 1);
    ov_fault = 1'b1;
    @(negedge clk);
    chk("R9", "ready under ov", vr_ready, 0);
    chk("R9", "dac kept under ov", dac_code, 198);
    ov_fault = 1'b0;
    @(negedge clk);
    chk("R9", "ready after ov clears", vr_ready, 1);

    // R11: OFF code while running
    vid_off = 1'b1;
    @(negedge clk);
    chk("R11", "ready after OFF in run", vr_ready, 0);
    repeat (3) @(negedge clk);
    chk("R11", "dac after OFF in run", dac_code, 0);
    vid_off = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10", "shutdown latched dac", dac_code, 0);
    chk("R10", "shutdown latched ready", vr_ready, 0);
    pwr_en = 1'b0;
    @(negedge clk);
    pwr_en = 1'b1;
    c0 = cyc + 1;
    wait_ne(0, t);
    chk("R10", "restart after pwr_en cycle", t - c0, D + 1);

    // R12: enable loss during the first ramp
    wait_eq(50, t);
    vtt_en = 1'b0;
    @(negedge clk);
    chk("R12", "dac after vtt drop", dac_code, 0);
    chk("R12", "ready after vtt drop", vr_ready, 0);
    repeat (20) @(negedge clk);
    chk("R12", "dac while vtt low", dac_code, 0);
    vtt_en = 1'b1;
    c0 = cyc + 1;
    wait_ne(0, t);
    chk("R12", "restart latency", t - c0, D + 1);
    wait_rdy(tr);

    // R7: downward second ramp to 150-2
    vid_code = 8'd150;
    sb_ramp(0, 176); sb_ramp(176, 148);
    restart(1'b1, c0);
    wait_eq(176, tb);
    wait_rdy(tr);
    chk("R8", "ready after down ramp", tr - tb, H + V + R + 3 + 28);
    chk("R7", "down ramp final code", dac_code, 148);
    sb_done("R7");

    // R4: no tick, no step
    ss_tick = 1'b0;
    restart(1'b0, c0);
    repeat (D + 30) @(negedge clk);
    chk("R4", "dac without ticks", dac_code, 0);
    ss_tick = 1'b1;
    @(negedge clk);
    ss_tick = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4", "dac after single tick", dac_code, 1);
    ss_tick = 1'b1;

    // R6: late and short VID valid
    vid_valid = 1'b0;
    restart(1'b0, c0);
    wait_eq(176, tb);
    repeat (H + 20) @(negedge clk);
    chk("R6", "no ramp without valid", dac_code, 176);
    vid_valid = 1'b1;
    repeat (2) @(negedge clk);
    vid_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6", "short valid pulse ignored", dac_code, 176);
    vid_valid = 1'b1;
    x = cyc + 1;
    wait_ne(176, t);
    chk("R6", "qualification latency", t - x, V);
    wait_rdy(tr);

    // R10: OFF code at the sample
    vid_off = 1'b1;
    restart(1'b0, c0);
    wait_eq(176, tb);
    repeat (H + V + 10) @(negedge clk);
    chk("R10", "dac after OFF sample", dac_code, 0);
    chk("R10", "ready after OFF sample", vr_ready, 0);
    vid_off = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10", "latched with valid VID", dac_code, 0);
    vtt_en = 1'b0;
    @(negedge clk);
    vtt_en = 1'b1;
    c0 = cyc + 1;
    wait_ne(0, t);
    chk("R10", "restart after vtt cycle", t - c0, D + 1);

    // R7: target floored at zero (1-2)
    vid_code = 8'd1;
    sb_ramp(0, 176); sb_ramp(176, 0);
    restart(1'b1, c0);
    wait_eq(176, tb);
    wait_rdy(tr);
    chk("R8", "ready after ramp to zero", tr - tb, H + V + R + 3 + 176);
    chk("R7", "floored target", dac_code, 0);
    sb_done("R7");

    // R8: target equal to boot (178-2)
    vid_code = 8'd178;
    restart(1'b0, c0);
    wait_eq(176, tb);
    wait_rdy(tr);
    chk("R8", "ready with target at boot", tr - tb, H + V + R + 3);
    chk("R7", "code with target at boot", dac_code, 176);

    summary();
    $finish;
  end

endmodule